// File: doc/BRIEF.md
# Surface Address Register Bank

This block holds the address setup for up to seven render surfaces. Each surface has an offset, a base and a limit register, and there are six pitch registers. Beside them sit a control word, a flag word with one bit per surface, and a field word with one 4-bit field per surface. Software reaches all of them through a single 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the addressed register.

Offset and base writes have a side effect. Surfaces are grouped in even/odd pairs, such as (2,3), (4,5) and (6,7). An offset or base write clears the flag bits and the 4-bit fields of both surfaces in its pair. Control bit 20 suppresses this clearing.

Two sticky status outputs are also kept. One records that any offset register has been written. The other records that any pitch register has been written.

Top module: `surf_addr_bank`

## Requirements
- R1: After reset, every register reads as zero and both `offs_valid_o` and `pitch_valid_o` are 0.
- R2: Each stored value is the write data ANDed with a writable mask, and it reads back at its own address.
  - Offset i (0..5) is at 0x820+4i and base i at 0x838+4i, both with mask 0x03ffffff.
  - Limit i (0..5) is at 0x864+4i with mask 0x83ffffff, so bits 30..26 always read 0.
  - Pitch i (0..4) is at 0x850+4i with mask 0x0000fff0.
- R3: Surface 6 has its offset at 0x880, its base at 0x884 and its limit at 0x88c, with the same masks as R2. The sixth pitch register (index 5) is at 0x888.
- R4: The control word at 0x890 is fully writable. The flag word at 0x898 stores mask 0x7f, where bit i belongs to surface i. The field word at 0x89c stores mask 0x0fffffff, where bits 4i+3..4i belong to surface i. Both words can be written directly.
- R5: A write to offset or base i while control bit 20 is 0 clears flag bits (i&~1) and (i|1). It also clears the 4-bit fields at 4·(i&~1) and 4·(i|1). Positions above the stored width are not kept.
- R6: While control bit 20 is 1, offset and base writes leave the flag and field words unchanged.
- R7: Any offset write sets `offs_valid_o` and any pitch write sets `pitch_valid_o`. Both stay set until reset. Base and limit writes set neither.
- R8: Reads from unmapped addresses return zero. Writes to unmapped addresses change no register.
- R9: Limit, pitch and control writes leave the flag and field words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 12 | Register address (read and write) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| offs_valid_o | output | 1 | Sticky: an offset register was written |
| pitch_valid_o | output | 1 | Sticky: a pitch register was written |

## Verification
The pair-clearing side effect is tried with offset writes and base writes to low, middle and top surfaces. Each write lands on a flag and field word preloaded with all ones, so the cleared pair can be told apart from its neighbours. The same write is repeated with the suppress bit set, which shows that the clearing is gated and not unconditional. Limit and pitch writes into the same preloaded words show that only offset and base writes clear anything. Writes of all ones to every register class expose each writable mask.

// File: rtl/surf_bank_pkg.sv
package surf_bank_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_SURF  = 7;
  localparam int unsigned N_PITCH = 6;
  localparam int unsigned N_LOW   = N_SURF - 1;   // surfaces in the contiguous bank
  localparam int unsigned FLD_W   = 4;
  localparam int unsigned FLAG_W  = N_SURF;
  localparam int unsigned FIELD_W = N_SURF * FLD_W;
  localparam int unsigned SUPPRESS_BIT = 20;

  localparam logic [ADDR_W-1:0] A_OFFS_LO  = 12'h820;
  localparam logic [ADDR_W-1:0] A_BASE_LO  = 12'h838;
  localparam logic [ADDR_W-1:0] A_PITCH_LO = 12'h850;
  localparam logic [ADDR_W-1:0] A_LIMIT_LO = 12'h864;
  localparam logic [ADDR_W-1:0] A_OFFS_HI  = 12'h880;
  localparam logic [ADDR_W-1:0] A_BASE_HI  = 12'h884;
  localparam logic [ADDR_W-1:0] A_PITCH_HI = 12'h888;
  localparam logic [ADDR_W-1:0] A_LIMIT_HI = 12'h88c;
  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h890;
  localparam logic [ADDR_W-1:0] A_FLAG     = 12'h898;
  localparam logic [ADDR_W-1:0] A_FIELD    = 12'h89c;

  typedef enum logic [2:0] {
    K_NONE, K_OFFS, K_BASE, K_LIMIT, K_PITCH, K_CTRL, K_FLAG, K_FIELD
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] idx;
  } reg_sel_t;
endpackage

// File: rtl/surf_addr_decode.sv
module surf_addr_decode
  import surf_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o = '{kind: K_NONE, idx: 3'd0};
    for (int i = 0; i < int'(N_LOW); i++) begin
      if (addr_i == A_OFFS_LO + ADDR_W'(4 * i))
        sel_o = '{kind: K_OFFS, idx: 3'(i)};
      if (addr_i == A_BASE_LO + ADDR_W'(4 * i))
        sel_o = '{kind: K_BASE, idx: 3'(i)};
      if (addr_i == A_LIMIT_LO + ADDR_W'(4 * i))
        sel_o = '{kind: K_LIMIT, idx: 3'(i)};
    end
    for (int i = 0; i < int'(N_PITCH) - 1; i++) begin
      if (addr_i == A_PITCH_LO + ADDR_W'(4 * i))
        sel_o = '{kind: K_PITCH, idx: 3'(i)};
    end
    case (addr_i)
      A_OFFS_HI:  sel_o = '{kind: K_OFFS,  idx: 3'(N_SURF - 1)};
      A_BASE_HI:  sel_o = '{kind: K_BASE,  idx: 3'(N_SURF - 1)};
      A_LIMIT_HI: sel_o = '{kind: K_LIMIT, idx: 3'(N_SURF - 1)};
      A_PITCH_HI: sel_o = '{kind: K_PITCH, idx: 3'(N_PITCH - 1)};
      A_CTRL:     sel_o = '{kind: K_CTRL,  idx: 3'd0};
      A_FLAG:     sel_o = '{kind: K_FLAG,  idx: 3'd0};
      A_FIELD:    sel_o = '{kind: K_FIELD, idx: 3'd0};
      default: ;
    endcase
  end
endmodule

// File: rtl/surf_geom_regs.sv
module surf_geom_regs
  import surf_bank_pkg::*;
#(
  parameter int unsigned OFFS_W     = 26,
  parameter logic [31:0] PITCH_MASK = 32'h0000fff0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_t          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] OFFS_MASK  = DATA_W'((64'd1 << OFFS_W) - 1);
  localparam logic [DATA_W-1:0] LIMIT_MASK = OFFS_MASK | 32'h8000_0000;

  logic [DATA_W-1:0] offs_q  [N_SURF];
  logic [DATA_W-1:0] base_q  [N_SURF];
  logic [DATA_W-1:0] limit_q [N_SURF];
  logic [DATA_W-1:0] pitch_q [N_PITCH];

  for (genvar s = 0; s < int'(N_SURF); s++) begin : g_surf
    logic hit;
    assign hit = we_i && (sel_i.idx == 3'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        offs_q[s]  <= '0;
        base_q[s]  <= '0;
        limit_q[s] <= '0;
      end else if (hit) begin
        if (sel_i.kind == K_OFFS)  offs_q[s]  <= wdata_i & OFFS_MASK;
        if (sel_i.kind == K_BASE)  base_q[s]  <= wdata_i & OFFS_MASK;
        if (sel_i.kind == K_LIMIT) limit_q[s] <= wdata_i & LIMIT_MASK;
      end
    end
  end

  for (genvar p = 0; p < int'(N_PITCH); p++) begin : g_pitch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pitch_q[p] <= '0;
      else if (we_i && sel_i.kind == K_PITCH && sel_i.idx == 3'(p))
        pitch_q[p] <= wdata_i & PITCH_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < int'(N_SURF); s++) begin
      if (sel_i.idx == 3'(s)) begin
        if (sel_i.kind == K_OFFS)  rdata_o = offs_q[s];
        if (sel_i.kind == K_BASE)  rdata_o = base_q[s];
        if (sel_i.kind == K_LIMIT) rdata_o = limit_q[s];
      end
    end
    for (int p = 0; p < int'(N_PITCH); p++) begin
      if (sel_i.kind == K_PITCH && sel_i.idx == 3'(p)) rdata_o = pitch_q[p];
    end
  end
endmodule

// File: rtl/surf_pair_flags.sv
module surf_pair_flags
  import surf_bank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  reg_sel_t           sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [FLAG_W-1:0]  flag_o,
  output logic [FIELD_W-1:0] field_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0]  ctrl_q;
  logic [FLAG_W-1:0]  flag_q;
  logic [FIELD_W-1:0] field_q;
  logic               pair_clr;
  logic [FLAG_W-1:0]  flag_kill;
  logic [FIELD_W-1:0] field_kill;

  assign pair_clr = we_i && (sel_i.kind == K_OFFS || sel_i.kind == K_BASE)
                    && !ctrl_q[SUPPRESS_BIT];

  // surfaces sharing idx>>1 form a pair
  for (genvar j = 0; j < int'(N_SURF); j++) begin : g_kill
    assign flag_kill[j] = pair_clr && (3'(j >> 1) == (sel_i.idx >> 1));
    assign field_kill[j*FLD_W +: FLD_W] = {FLD_W{flag_kill[j]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flag_q  <= '0;
      field_q <= '0;
    end else if (we_i) begin
      if (sel_i.kind == K_CTRL)  ctrl_q  <= wdata_i;
      if (sel_i.kind == K_FLAG)  flag_q  <= wdata_i[FLAG_W-1:0];
      else                       flag_q  <= flag_q & ~flag_kill;
      if (sel_i.kind == K_FIELD) field_q <= wdata_i[FIELD_W-1:0];
      else                       field_q <= field_q & ~field_kill;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign flag_o  = flag_q;
  assign field_o = field_q;

  always_comb begin
    unique case (sel_i.kind)
      K_CTRL:  rdata_o = ctrl_q;
      K_FLAG:  rdata_o = DATA_W'(flag_q);
      K_FIELD: rdata_o = DATA_W'(field_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/surf_addr_bank.sv
module surf_addr_bank
  import surf_bank_pkg::*;
#(
  parameter int unsigned OFFS_W     = 26,
  parameter logic [31:0] PITCH_MASK = 32'h0000fff0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              offs_valid_o,
  output logic              pitch_valid_o
);
  reg_sel_t           sel;
  logic [DATA_W-1:0]  geom_rdata, flag_rdata;
  logic [DATA_W-1:0]  ctrl_q;
  logic [FLAG_W-1:0]  flag_q;
  logic [FIELD_W-1:0] field_q;
  logic               offs_seen_q, pitch_seen_q;

  surf_addr_decode u_dec (.addr_i(addr_i), .sel_o(sel));

  surf_geom_regs #(.OFFS_W(OFFS_W), .PITCH_MASK(PITCH_MASK)) u_geom (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i), .sel_i(sel),
    .wdata_i(wdata_i), .rdata_o(geom_rdata)
  );

  surf_pair_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i), .sel_i(sel),
    .wdata_i(wdata_i), .ctrl_o(ctrl_q), .flag_o(flag_q), .field_o(field_q),
    .rdata_o(flag_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offs_seen_q  <= 1'b0;
      pitch_seen_q <= 1'b0;
    end else if (wr_en_i) begin
      if (sel.kind == K_OFFS)  offs_seen_q  <= 1'b1;
      if (sel.kind == K_PITCH) pitch_seen_q <= 1'b1;
    end
  end

  assign rdata_o       = geom_rdata | flag_rdata;
  assign offs_valid_o  = offs_seen_q;
  assign pitch_valid_o = pitch_seen_q;
endmodule

// File: rtl/surf_addr_bank_chk.sv
module surf_addr_bank_chk
  import surf_bank_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               offs_valid_o,
  input logic               pitch_valid_o,
  input logic [DATA_W-1:0]  ctrl_q,
  input logic [FLAG_W-1:0]  flag_q,
  input logic [FIELD_W-1:0] field_q
);
  logic               is_offs, is_base, is_pitch, mapped;
  logic [2:0]         surf;
  logic [FLAG_W-1:0]  fmask;
  logic [FIELD_W-1:0] dmask;

  always_comb begin
    is_offs = (addr_i == A_OFFS_HI) ||
              (addr_i >= A_OFFS_LO && addr_i < A_BASE_LO && addr_i[1:0] == 2'b00);
    is_base = (addr_i == A_BASE_HI) ||
              (addr_i >= A_BASE_LO && addr_i < A_PITCH_LO && addr_i[1:0] == 2'b00);
    is_pitch = (addr_i == A_PITCH_HI) ||
               (addr_i >= A_PITCH_LO && addr_i < A_LIMIT_LO && addr_i[1:0] == 2'b00);
    mapped = addr_i[1:0] == 2'b00 &&
             ((addr_i >= A_OFFS_LO && addr_i < A_LIMIT_LO + 12'h18) ||
              (addr_i >= A_OFFS_HI && addr_i <= A_CTRL) ||
              addr_i == A_FLAG || addr_i == A_FIELD);
    if (addr_i == A_OFFS_HI || addr_i == A_BASE_HI) surf = 3'd6;
    else if (is_offs) surf = 3'((addr_i - A_OFFS_LO) >> 2);
    else              surf = 3'((addr_i - A_BASE_LO) >> 2);
    fmask = FLAG_W'(7'b11 << (2 * (surf >> 1)));
    dmask = FIELD_W'(28'hff << (8 * (surf >> 1)));
  end

  // R5
  pair_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (is_offs || is_base) && !ctrl_q[SUPPRESS_BIT]
    |=> ((flag_q & $past(fmask)) == '0) && ((field_q & $past(dmask)) == '0));
  // R6
  suppress_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (is_offs || is_base) && ctrl_q[SUPPRESS_BIT]
    |=> $stable(flag_q) && $stable(field_q));
  // R7
  offs_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && is_offs |=> offs_valid_o);
  // R7
  pitch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && is_pitch |=> pitch_valid_o);
  // R7
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(offs_valid_o) && !$fell(pitch_valid_o));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0);
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(flag_q) && $stable(field_q) && $stable(ctrl_q));
endmodule

bind surf_addr_bank surf_addr_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .offs_valid_o(offs_valid_o), .pitch_valid_o(pitch_valid_o),
  .ctrl_q(ctrl_q), .flag_q(flag_q), .field_q(field_q)
);

// File: tb/tb_surf_addr_bank.sv
module tb_surf_addr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        offs_valid, pitch_valid;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  surf_addr_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .offs_valid_o(offs_valid),
    .pitch_valid_o(pitch_valid)
  );

  // {we, req, addr, data/expected}
  localparam int NV = 32;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 4'd4, 12'h898, 32'hffffffff}, {1'b0, 4'd4, 12'h898, 32'h0000007f},
    {1'b1, 4'd4, 12'h89c, 32'hffffffff}, {1'b0, 4'd4, 12'h89c, 32'h0fffffff},
    {1'b1, 4'd2, 12'h828, 32'hffffffff}, {1'b0, 4'd2, 12'h828, 32'h03ffffff},
    {1'b0, 4'd5, 12'h898, 32'h00000073}, {1'b0, 4'd5, 12'h89c, 32'h0fff00ff},
    {1'b1, 4'd2, 12'h84c, 32'h12345678}, {1'b0, 4'd2, 12'h84c, 32'h02345678},
    {1'b0, 4'd5, 12'h898, 32'h00000043}, {1'b0, 4'd5, 12'h89c, 32'h0f0000ff},
    {1'b1, 4'd4, 12'h890, 32'h00100000}, {1'b0, 4'd4, 12'h890, 32'h00100000},
    {1'b1, 4'd6, 12'h898, 32'h0000007f}, {1'b1, 4'd6, 12'h820, 32'h00000040},
    {1'b0, 4'd6, 12'h898, 32'h0000007f}, {1'b0, 4'd6, 12'h89c, 32'h0f0000ff},
    {1'b1, 4'd6, 12'h890, 32'h00000000}, {1'b1, 4'd3, 12'h884, 32'hffffffff},
    {1'b0, 4'd3, 12'h884, 32'h03ffffff}, {1'b0, 4'd5, 12'h898, 32'h0000003f},
    {1'b0, 4'd5, 12'h89c, 32'h000000ff}, {1'b1, 4'd3, 12'h888, 32'hffffffff},
    {1'b0, 4'd3, 12'h888, 32'h0000fff0}, {1'b1, 4'd3, 12'h88c, 32'hffffffff},
    {1'b0, 4'd3, 12'h88c, 32'h83ffffff}, {1'b0, 4'd9, 12'h898, 32'h0000003f},
    {1'b1, 4'd2, 12'h864, 32'h7c000001}, {1'b0, 4'd2, 12'h864, 32'h00000001},
    {1'b1, 4'd2, 12'h850, 32'h00001234}, {1'b0, 4'd2, 12'h850, 32'h00001230}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 check(req, rdata, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1", 12'h820, 32'h0); rd("R1", 12'h88c, 32'h0);
    rd("R1", 12'h890, 32'h0); rd("R1", 12'h898, 32'h0);
    check("R1", {31'b0, offs_valid}, 32'h0);
    check("R1", {31'b0, pitch_valid}, 32'h0);
    rst_n = 1'b1;
    // R7 base and limit set nothing; offset and pitch do
    wr(12'h838, 32'h100); wr(12'h864, 32'h100);
    #1 check("R7", {30'b0, offs_valid, pitch_valid}, 32'h0);
    wr(12'h820, 32'h10);
    #1 check("R7", {30'b0, offs_valid, pitch_valid}, 32'h2);
    wr(12'h854, 32'h20);
    #1 check("R7", {30'b0, offs_valid, pitch_valid}, 32'h3);
    // R9 limit write and R2/R3/R4/R5/R6 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][43:32], VEC[i][31:0]);
      else rd($sformatf("R%0d", VEC[i][47:44]), VEC[i][43:32], VEC[i][31:0]);
    end
    // R8 unmapped: write ignored, read zero, neighbours intact
    wr(12'h8a0, 32'hffffffff);
    rd("R8", 12'h8a0, 32'h0); rd("R8", 12'h822, 32'h0);
    rd("R8", 12'h84c, 32'h02345678); rd("R8", 12'h89c, 32'h000000ff);
    // R5 surface 1 offset write clears pair (0,1)
    wr(12'h898, 32'h7f); wr(12'h824, 32'h0);
    rd("R5", 12'h898, 32'h0000007c);
    // R1 reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    rd("R1", 12'h84c, 32'h0); rd("R1", 12'h89c, 32'h0);
    check("R1", {30'b0, offs_valid, pitch_valid}, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule